// File: doc/BRIEF.md
# Sample ROM Bank Selector

This block holds the base offset of a 256 KB window into a sample ROM read by an ADPCM playback engine. A processor loads it by writing one byte to a bank port. A static configuration input gives the number of 256 KB banks fitted. That count chooses how the byte is decoded.

With three banks or fewer, two bits of the byte act as flags that pick one of three fixed windows. With four or more banks, the low three bits form a bank number counted from one. In that mode the value zero leaves the window where it was.

The block also adds its base offset to the engine's 18-bit in-window address, which gives the full ROM address. The result is registered. The base offset is `WIN_BITS + SEL_W` bits wide, which is 21 bits with the default parameters, so bank numbers up to 7 map without wrapping.

Top module: `sample_bank_sel`

## Requirements
- R1: After synchronous reset, `base_off` and `rom_addr` are both zero.
- R2: Small mode applies when `banks_fitted` <= 3. In that mode a write with bit 2 of the byte clear sets `base_off` to 0. This includes a write of 0x00.
- R3: In small mode, a write with bit 2 set and bit 0 set sets `base_off` to 0x40000.
- R4: In small mode, a write with bit 2 set and bit 0 clear sets `base_off` to 0x80000. Bits 7:3 and bit 1 have no effect.
- R5: Large mode applies when `banks_fitted` >= 4. A write whose bits 2:0 hold a nonzero value v sets `base_off` to (v-1)*0x40000. Bits 7:3 have no effect.
- R6: In large mode, a write whose bits 2:0 are zero leaves `base_off` unchanged.
- R7: In a cycle without `bank_wr`, `base_off` keeps its value.
- R8: `rom_addr` equals the sum of `base_off` and `dev_addr` as they stood one clock earlier.
- R9: `banks_fitted` is sampled in the write cycle. The value 3 selects small mode and the value 4 selects large mode. `base_off` changes on the clock edge that samples `bank_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_wr | input | 1 | Bank port write strobe, one cycle per write |
| bank_data | input | 8 | Byte written to the bank port |
| banks_fitted | input | 4 | Number of 256 KB banks present |
| dev_addr | input | 18 | Address inside the window from the playback engine |
| base_off | output | 21 | Registered window base offset |
| rom_addr | output | 21 | Registered full ROM address |

## Verification
The hardest case to reach is the hold-on-zero behaviour in large mode. It can only be seen when the base is already nonzero and a large-mode zero is written straight after a write that moved the base. Otherwise the "unchanged" value cannot be told apart from reset.

The stimulus therefore moves the base to the top bank and then writes a byte whose low bits are zero and whose upper bits are set. It also repeats writes across the 3/4 bank-count boundary with the same byte, so a misplaced mode threshold shows up as a different base.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic {
    DEC_FLAGS  = 1'b0,
    DEC_NUMBER = 1'b1
  } dec_mode_e;

  localparam int FLAG_EN_BIT  = 2;
  localparam int FLAG_SEL_BIT = 0;
endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
  import sbs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 4,
  parameter int SEL_W     = 3,
  parameter int WIN_BITS  = 18,
  parameter int SMALL_MAX = 3,
  localparam int BASE_W   = WIN_BITS + SEL_W
) (
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  count,
  output logic              load,
  output logic [BASE_W-1:0] next_base
);
  dec_mode_e        mode;
  logic [SEL_W-1:0] bank_num;
  logic [SEL_W-1:0] bank_idx;

  assign mode     = (count > CNT_W'(SMALL_MAX)) ? DEC_NUMBER : DEC_FLAGS;
  assign bank_num = data[SEL_W-1:0];

  always_comb begin
    load     = 1'b1;
    bank_idx = '0;
    if (mode == DEC_FLAGS) begin
      if (!data[FLAG_EN_BIT])       bank_idx = SEL_W'(0);
      else if (data[FLAG_SEL_BIT])  bank_idx = SEL_W'(1);
      else                          bank_idx = SEL_W'(2);
    end else begin
      if (bank_num == '0) load = 1'b0;
      bank_idx = bank_num - SEL_W'(1);
    end
  end

  assign next_base = {bank_idx, {WIN_BITS{1'b0}}};
endmodule

// File: rtl/sbs_base_reg.sv
module sbs_base_reg #(
  parameter int BASE_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              load,
  input  logic [BASE_W-1:0] next_base,
  output logic [BASE_W-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (rst)              base_q <= '0;
    else if (wr && load)  base_q <= next_base;
  end
endmodule

// File: rtl/sbs_addr_sum.sv
module sbs_addr_sum #(
  parameter int WIN_BITS = 18,
  parameter int BASE_W   = 21
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BASE_W-1:0]   base,
  input  logic [WIN_BITS-1:0] offs,
  output logic [BASE_W-1:0]   sum_q
);
  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= base + BASE_W'(offs);
  end
endmodule

// File: rtl/sample_bank_sel.sv
module sample_bank_sel #(
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 4,
  parameter int SEL_W     = 3,
  parameter int WIN_BITS  = 18,
  parameter int SMALL_MAX = 3,
  localparam int BASE_W   = WIN_BITS + SEL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bank_wr,
  input  logic [DATA_W-1:0]   bank_data,
  input  logic [CNT_W-1:0]    banks_fitted,
  input  logic [WIN_BITS-1:0] dev_addr,
  output logic [BASE_W-1:0]   base_off,
  output logic [BASE_W-1:0]   rom_addr
);
  logic              dec_load;
  logic [BASE_W-1:0] dec_base;

  sbs_decode #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W),
    .WIN_BITS(WIN_BITS), .SMALL_MAX(SMALL_MAX)
  ) u_dec (
    .data(bank_data), .count(banks_fitted),
    .load(dec_load), .next_base(dec_base)
  );

  sbs_base_reg #(.BASE_W(BASE_W)) u_base (
    .clk(clk), .rst(rst), .wr(bank_wr), .load(dec_load),
    .next_base(dec_base), .base_q(base_off)
  );

  sbs_addr_sum #(.WIN_BITS(WIN_BITS), .BASE_W(BASE_W)) u_sum (
    .clk(clk), .rst(rst), .base(base_off), .offs(dev_addr),
    .sum_q(rom_addr)
  );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 4,
  parameter int WIN_BITS  = 18,
  parameter int BASE_W    = 21,
  parameter int SMALL_MAX = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                bank_wr,
  input logic [DATA_W-1:0]   bank_data,
  input logic [CNT_W-1:0]    banks_fitted,
  input logic [WIN_BITS-1:0] dev_addr,
  input logic [BASE_W-1:0]   base_off,
  input logic [BASE_W-1:0]   rom_addr
);
  logic live  = 1'b0;
  logic rst_d = 1'b0;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    live  <= !rst;
  end

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (base_off == '0 && rom_addr == '0));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (live && !$past(bank_wr)) |-> base_off == $past(base_off));

  a_r6_zero_hold: assert property (@(posedge clk) disable iff (rst)
    (live && $past(bank_wr) && $past(banks_fitted) > CNT_W'(SMALL_MAX)
     && $past(bank_data[2:0]) == 3'd0) |-> base_off == $past(base_off));

  a_r3_flag_one: assert property (@(posedge clk) disable iff (rst)
    (live && $past(bank_wr) && $past(banks_fitted) <= CNT_W'(SMALL_MAX)
     && $past(bank_data[2]) && $past(bank_data[0]))
    |-> base_off == BASE_W'(32'h40000));

  a_r2_flag_off: assert property (@(posedge clk) disable iff (rst)
    (live && $past(bank_wr) && $past(banks_fitted) <= CNT_W'(SMALL_MAX)
     && !$past(bank_data[2])) |-> base_off == '0);

  a_r8_sum: assert property (@(posedge clk) disable iff (rst)
    live |-> rom_addr == $past(base_off) + BASE_W'($past(dev_addr)));
endmodule

bind sample_bank_sel sbs_checker #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .WIN_BITS(WIN_BITS),
  .BASE_W(BASE_W), .SMALL_MAX(SMALL_MAX)
) u_chk (
  .clk(clk), .rst(rst), .bank_wr(bank_wr), .bank_data(bank_data),
  .banks_fitted(banks_fitted), .dev_addr(dev_addr),
  .base_off(base_off), .rom_addr(rom_addr)
);

// File: tb/sample_bank_sel_test.sv
module sample_bank_sel_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bank_wr = 1'b0;
  logic [7:0]  bank_data = '0;
  logic [3:0]  banks_fitted = 4'd2;
  logic [17:0] dev_addr = '0;
  logic [20:0] base_off;
  logic [20:0] rom_addr;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    logic [20:0] exp;
    string       tag;
  } item_t;
  item_t       sb[$];
  logic [20:0] model = '0;
  logic        wr_seen = 1'b0;

  always #10 clk = ~clk;

  sample_bank_sel uut (
    .clk(clk), .rst(rst), .bank_wr(bank_wr), .bank_data(bank_data),
    .banks_fitted(banks_fitted), .dev_addr(dev_addr),
    .base_off(base_off), .rom_addr(rom_addr)
  );

  function automatic logic [20:0] next_model(logic [20:0] cur, logic [7:0] d,
                                             logic [3:0] cnt);
    if (cnt <= 4'd3) begin
      if (!d[2])     return 21'h0;
      else if (d[0]) return 21'h40000;
      else           return 21'h80000;
    end
    if (d[2:0] == 3'd0) return cur;
    return 21'(d[2:0] - 3'd1) << 18;
  endfunction

  task automatic check(string tag, logic [20:0] act, logic [20:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bank_write(logic [7:0] d, logic [3:0] cnt, string tag);
    item_t it;
    @(negedge clk);
    bank_data    = d;
    banks_fitted = cnt;
    bank_wr      = 1'b1;
    model        = next_model(model, d, cnt);
    it.exp = model;
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    bank_wr = 1'b0;
  endtask

  always @(posedge clk) wr_seen <= bank_wr;

  always @(negedge clk) begin
    if (wr_seen && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(it.tag, base_off, it.exp);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 base", base_off, 21'h0);
    check("R1 rom", rom_addr, 21'h0);
    rst = 1'b0;

    bank_write(8'h05, 4'd2, "R3 small sel1");
    bank_write(8'h04, 4'd2, "R4 small sel2");
    bank_write(8'hFA, 4'd2, "R2 small off");
    bank_write(8'hFE, 4'd1, "R4 small ignores high bits");
    bank_write(8'h05, 4'd3, "R9 count 3 small");
    bank_write(8'h05, 4'd4, "R9 R5 count 4 large");
    bank_write(8'h01, 4'd8, "R5 large v1");
    bank_write(8'hF7, 4'd8, "R5 large v7 high bits");
    bank_write(8'hF8, 4'd8, "R6 large zero holds");
    bank_write(8'h00, 4'd15, "R6 large zero holds again");
    bank_write(8'h0A, 4'd8, "R5 large v2");

    @(negedge clk);
    bank_data = 8'h07;
    banks_fitted = 4'd8;
    repeat (3) @(negedge clk);
    check("R7 idle hold", base_off, model);

    dev_addr = 18'h3FFFF;
    @(negedge clk);
    check("R8 sum max offs", rom_addr, model + 21'h3FFFF);
    dev_addr = 18'h00123;
    @(negedge clk);
    check("R8 sum small offs", rom_addr, model + 21'h00123);

    bank_write(8'h00, 4'd2, "R2 small zero");
    @(negedge clk);
    check("R8 after bank change", rom_addr, 21'h00123);

    repeat (2) @(negedge clk);
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R9: got %0d pending expected 0", sb.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule